// File: doc/BRIEF.md
# DMA Start Trigger Selector

This block sits between a bank of peripheral interrupt request lines and a DMA transfer engine. It serves four channels. Each channel has one byte-wide trigger register. The register holds a pending-request flag and a source select field that names one of up to 64 interrupt lines. A rising edge on the selected line latches the flag. The flag latches whether or not the channel is enabled. Once the channel is enabled, a stored flag becomes a start request to the engine, and the request stays up until the engine accepts it.

Software reads and writes the trigger registers over a plain register port. A byte write updates the select field. A single-bit write touches only the flag. Writing the flag as 0 discards a stale request. Writing the flag as 1 has no effect, so only hardware can set it. Interrupt edges that arrive while the standby indication is high are dropped. A channel initialize input also clears the flag.

The start request toward the engine is a valid/ready pair per channel. `start_valid` stays high while the flag is set and the channel is enabled. A transfer is accepted on a cycle where both `start_valid` and `start_ready` are high. `start_valid` may fall without acceptance only when software or the channel control withdraws the request: enable low, an initialize pulse, or a software clear. A select change made while the channel is enabled takes effect, but it raises a sticky protocol error.

Top module: `dma_trig_sel`

## Requirements
- R1: After reset, every trigger register reads 0x00, every `start_valid` is low and `sel_err` is low.
- R2: `reg_rdata` shows the register picked by `reg_addr` in the same cycle: bit 7 is the flag, bit 6 always reads 0, and bits 5:0 hold the select value.
- R3: A byte write (`reg_wr`) loads `reg_wdata[5:0]` into the addressed select field; `reg_wdata[6]` is ignored.
- R4: When the select value is nonzero, a rising edge on `irq_in[select]` sets the flag at the next clock edge, whether the channel is enabled or not.
- R5: Select value 0 connects no source, so no edge on any line sets that flag.
- R6: An edge seen while `standby` is high does not set any flag, and it is not remembered after `standby` falls.
- R7: `start_valid[n]` is high exactly when flag n is set and `ch_en[n]` is high, with no cycle of delay, so enabling a channel that holds a stored request starts a transfer at once.
- R8: A cycle with `start_valid[n]` and `start_ready[n]` both high clears flag n. If a selected edge arrives in that same cycle, the flag stays set.
- R9: A byte write or a single-bit write (`reg_bwr`) with `reg_wdata[7]` = 0 clears the addressed flag. Either write with bit 7 = 1 leaves the flag unchanged. A single-bit write leaves the select field unchanged.
- R10: A pulse on `ch_init[n]` clears flag n, unless a selected edge arrives in the same cycle.
- R11: A byte write to a channel whose `ch_en` is high sets `sel_err`. `sel_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Channel register index |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Byte write strobe |
| reg_bwr | input | 1 | Single-bit flag write strobe, value in bit 7 |
| reg_rdata | output | 8 | Read data of addressed register |
| irq_in | input | 64 | Peripheral interrupt request levels |
| standby | input | 1 | Standby indication, drops interrupt edges |
| ch_en | input | 4 | Per-channel transfer enable |
| ch_init | input | 4 | Per-channel initialize pulse |
| start_valid | output | 4 | Start request to the engine |
| start_ready | input | 4 | Engine accepts the start request |
| sel_err | output | 1 | Sticky select-while-enabled error |

## Verification
The checker assumes that the interrupt lines are low while reset is asserted, because an edge is judged against the last sampled level. It also assumes that a byte write and a single-bit write are never strobed together. The randomized stimulus keeps every interrupt line at 0 until reset is released. It picks at most one bus operation per cycle. It also draws select values mostly from the few lines it toggles, so that edges actually reach channels. The acceptance property uses cycles where no interrupt line is high at all. This keeps it free of the flag-set race, which the directed cases then cover explicitly.

// File: rtl/dma_trig_pkg.sv
`timescale 1ns/1ps
package dma_trig_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_POS = 7;
  localparam int FIELD_W  = 6;

  typedef struct packed {
    logic               flag;
    logic               rsvd;
    logic [FIELD_W-1:0] sel;
  } trig_reg_t;

  function automatic trig_reg_t pack_reg(input logic flag, input logic [FIELD_W-1:0] sel);
    trig_reg_t r;
    r.flag = flag;
    r.rsvd = 1'b0;
    r.sel  = sel;
    return r;
  endfunction
endpackage

// File: rtl/dma_trig_edge.sv
`timescale 1ns/1ps
module dma_trig_edge #(
  parameter int NIRQ = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_in,
  input  logic            standby,
  output logic [NIRQ-1:0] rise
);
  logic [NIRQ-1:0] irq_q;

  // previous level is always tracked, so an edge masked by standby is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_in;
  end

  assign rise = irq_in & ~irq_q & {NIRQ{~standby}};
endmodule

// File: rtl/dma_trig_chan.sv
`timescale 1ns/1ps
module dma_trig_chan #(
  parameter int SELW = 6,
  parameter int NIRQ = 1 << SELW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] rise,
  input  logic            en,
  input  logic            init,
  input  logic            wr_byte,
  input  logic            wr_bit,
  input  logic            wd_flag,
  input  logic [SELW-1:0] wd_sel,
  input  logic            accept,
  output logic            flag,
  output logic [SELW-1:0] sel,
  output logic            sel_viol
);
  logic hit;
  logic sw_clr;
  logic drop;

  assign hit    = (sel != '0) && rise[sel];
  assign sw_clr = (wr_byte | wr_bit) & ~wd_flag;
  assign drop   = accept | init | sw_clr;

  // a fresh edge outranks every clearing cause
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (hit)  flag <= 1'b1;
    else if (drop) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel <= '0;
    else if (wr_byte) sel <= wd_sel;
  end

  assign sel_viol = wr_byte & en;
endmodule

// File: rtl/dma_trig_sel.sv
`timescale 1ns/1ps
module dma_trig_sel
  import dma_trig_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SELW  = FIELD_W,
  parameter int NIRQ  = 1 << SELW,
  parameter int ADDRW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDRW-1:0]  reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_bwr,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NIRQ-1:0]   irq_in,
  input  logic              standby,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH-1:0]    ch_init,
  output logic [NCH-1:0]    start_valid,
  input  logic [NCH-1:0]    start_ready,
  output logic              sel_err
);
  logic [NIRQ-1:0] rise;
  logic [NCH-1:0]  flag;
  logic [NCH-1:0]  viol;
  trig_reg_t       regs [NCH];
  logic            unused_rsvd;

  assign unused_rsvd = reg_wdata[FLAG_POS-1];

  dma_trig_edge #(.NIRQ(NIRQ)) u_edge (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .standby(standby), .rise(rise)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic            hit_sel;
    logic [SELW-1:0] sel;
    assign hit_sel = (reg_addr == ADDRW'(g));

    dma_trig_chan #(.SELW(SELW), .NIRQ(NIRQ)) u_chan (
      .clk(clk), .rst_n(rst_n), .rise(rise),
      .en(ch_en[g]), .init(ch_init[g]),
      .wr_byte(reg_wr & hit_sel), .wr_bit(reg_bwr & hit_sel),
      .wd_flag(reg_wdata[FLAG_POS]), .wd_sel(reg_wdata[SELW-1:0]),
      .accept(start_valid[g] & start_ready[g]),
      .flag(flag[g]), .sel(sel), .sel_viol(viol[g])
    );

    assign regs[g]        = pack_reg(flag[g], FIELD_W'(sel));
    assign start_valid[g] = flag[g] & ch_en[g];
  end

  assign reg_rdata = regs[reg_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_err <= 1'b0;
    else if (|viol) sel_err <= 1'b1;
  end
endmodule

// File: rtl/dma_trig_sel_chk.sv
`timescale 1ns/1ps
module dma_trig_sel_chk #(
  parameter int NCH   = 4,
  parameter int NIRQ  = 64,
  parameter int ADDRW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ADDRW-1:0] reg_addr,
  input logic             reg_wr,
  input logic             reg_bwr,
  input logic [7:0]       reg_rdata,
  input logic [NIRQ-1:0]  irq_in,
  input logic             standby,
  input logic [NCH-1:0]   ch_en,
  input logic [NCH-1:0]   ch_init,
  input logic [NCH-1:0]   start_valid,
  input logic [NCH-1:0]   start_ready,
  input logic             sel_err
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[6] == 1'b0);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) sel_err |=> sel_err);

  // R6
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !reg_wr && !reg_bwr && ch_init == '0 && (start_valid & start_ready) == '0)
    |=> (!$stable(ch_en) || $stable(start_valid)));

  for (genvar g = 0; g < NCH; g++) begin : g_c
    // R7
    valid_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid[g] |-> ch_en[g]);

    // R8
    accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_valid[g] && start_ready[g] && irq_in == '0) |=> !start_valid[g]);
  end
endmodule

bind dma_trig_sel dma_trig_sel_chk #(.NCH(NCH), .NIRQ(NIRQ), .ADDRW(ADDRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_bwr(reg_bwr),
  .reg_rdata(reg_rdata), .irq_in(irq_in), .standby(standby), .ch_en(ch_en),
  .ch_init(ch_init), .start_valid(start_valid), .start_ready(start_ready), .sel_err(sel_err)
);

// File: tb/sim_dma_trig_sel.sv
`timescale 1ns/1ps
module sim_dma_trig_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_bwr = 1'b0;
  logic [7:0]  reg_rdata;
  logic [63:0] irq_in = '0;
  logic        standby = 1'b0;
  logic [3:0]  ch_en = '0;
  logic [3:0]  ch_init = '0;
  logic [3:0]  start_valid;
  logic [3:0]  start_ready = '0;
  logic        sel_err;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic        flag_m [4];
  logic [5:0]  sel_m  [4];
  logic        err_m;
  logic [63:0] prev_m;

  always #10 clk = ~clk;

  dma_trig_sel u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_bwr(reg_bwr), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .standby(standby), .ch_en(ch_en), .ch_init(ch_init), .start_valid(start_valid),
    .start_ready(start_ready), .sel_err(sel_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_flag(input logic cur, input logic [5:0] s, input logic [63:0] irq,
                                    input logic [63:0] prev, input logic stby, input logic clr);
    logic hit;
    hit = (s != 6'd0) && irq[s] && !prev[s] && !stby;
    if (hit) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic tick();
    #2;
    for (int c = 0; c < 4; c++)
      chk(start_valid[c] === (flag_m[c] & ch_en[c]), "R7", start_valid[c], flag_m[c] & ch_en[c]);
    chk(reg_rdata === {flag_m[reg_addr], 1'b0, sel_m[reg_addr]}, "R2", reg_rdata,
        {flag_m[reg_addr], 1'b0, sel_m[reg_addr]});
    chk(sel_err === err_m, "R11", sel_err, err_m);
    for (int c = 0; c < 4; c++) begin
      logic clr;
      clr = (flag_m[c] & ch_en[c] & start_ready[c]) | ch_init[c] |
            ((reg_wr | reg_bwr) && reg_addr == 2'(c) && !reg_wdata[7]);
      flag_m[c] = exp_flag(flag_m[c], sel_m[c], irq_in, prev_m, standby, clr);
      if (reg_wr && reg_addr == 2'(c)) begin
        sel_m[c] = reg_wdata[5:0];
        if (ch_en[c]) err_m = 1'b1;
      end
    end
    prev_m = irq_in;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    reg_bwr = 1'b0;
    ch_init = '0;
    start_ready = '0;
  endtask

  task automatic rd(input int c, input logic [7:0] exp, input string tag);
    reg_addr = 2'(c);
    #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int c = 0; c < 4; c++) begin flag_m[c] = 1'b0; sel_m[c] = '0; end
    err_m = 1'b0;
    prev_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int c = 0; c < 4; c++) rd(c, 8'h00, "R1");
    chk(start_valid === 4'h0, "R1", start_valid, 0);
    chk(sel_err === 1'b0, "R1", sel_err, 0);

    // R3 byte write, bit 6 ignored
    reg_addr = 0; reg_wdata = 8'h43; reg_wr = 1'b1; tick();
    rd(0, 8'h03, "R3");
    // R4 edge latched while disabled
    irq_in[3] = 1'b1; tick();
    rd(0, 8'h83, "R4");
    chk(start_valid[0] === 1'b0, "R4", start_valid[0], 0);
    // R7 enabling starts at once
    ch_en[0] = 1'b1; #1;
    chk(start_valid[0] === 1'b1, "R7", start_valid[0], 1);
    tick();
    // R8 accept clears
    irq_in[3] = 1'b0; start_ready[0] = 1'b1; tick();
    rd(0, 8'h03, "R8");
    // R8 set wins over accept
    irq_in[3] = 1'b1; tick();
    irq_in[3] = 1'b0; tick();
    irq_in[3] = 1'b1; start_ready[0] = 1'b1; tick();
    rd(0, 8'h83, "R8");
    irq_in[3] = 1'b0; start_ready[0] = 1'b1; tick();
    ch_en[0] = 1'b0; tick();

    // R5 select zero connects nothing
    reg_addr = 1; reg_wdata = 8'h00; reg_wr = 1'b1; tick();
    irq_in[0] = 1'b1; tick();
    irq_in[0] = 1'b0; tick();
    rd(1, 8'h00, "R5");

    // R6 standby drops edges
    reg_addr = 2; reg_wdata = 8'h05; reg_wr = 1'b1; tick();
    standby = 1'b1; irq_in[5] = 1'b1; tick();
    standby = 1'b0; tick();
    rd(2, 8'h05, "R6");
    // R9 write 1 no effect, write 0 clears, bit write keeps select
    irq_in[5] = 1'b0; tick();
    irq_in[5] = 1'b1; tick();
    rd(2, 8'h85, "R9");
    reg_wdata = 8'h80; reg_bwr = 1'b1; tick();
    rd(2, 8'h85, "R9");
    reg_wdata = 8'h00; reg_bwr = 1'b1; tick();
    rd(2, 8'h05, "R9");
    reg_wdata = 8'h85; reg_wr = 1'b1; tick();
    rd(2, 8'h05, "R9");
    // R10 init clears
    irq_in[5] = 1'b0; tick();
    irq_in[5] = 1'b1; tick();
    ch_init[2] = 1'b1; tick();
    rd(2, 8'h05, "R10");
    irq_in[5] = 1'b0; tick();

    // R11 sticky error
    ch_en[1] = 1'b1; reg_addr = 1; reg_wdata = 8'h02; reg_wr = 1'b1; tick();
    chk(sel_err === 1'b1, "R11", sel_err, 1);
    ch_en[1] = 1'b0; tick(); tick();
    chk(sel_err === 1'b1, "R11", sel_err, 1);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom % 16;
      reg_addr = 2'($urandom % 4);
      if (op == 0) begin
        reg_wdata = {1'($urandom), 1'($urandom), 6'($urandom % 8)};
        reg_wr = 1'b1;
      end else if (op == 1) begin
        reg_wdata = {1'($urandom), 7'($urandom)};
        reg_bwr = 1'b1;
      end
      for (int b = 0; b < 8; b++) if ($urandom % 5 == 0) irq_in[b] = ~irq_in[b];
      for (int c = 0; c < 4; c++) begin
        if ($urandom % 20 == 0) ch_en[c] = ~ch_en[c];
        ch_init[c] = ($urandom % 30 == 0);
        start_ready[c] = 1'($urandom);
      end
      standby = ($urandom % 10 == 0);
      tick();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule